// File: doc/BRIEF.md
# ECC Memory Bus Termination Controller

This block sits on the memory side of an asynchronous-style processor bus. It decides how each read cycle ends once an error-check stage has judged the RAM data. It drives three termination signals: a data acknowledge, a bus error and a halt/retry request. It also drives a one-clock strobe that tells the memory to rewrite the corrected word.

A two-bit policy select picks one of four termination policies. The acknowledge is either held back until the check result arrives (late) or given at once (early). Bad data is answered either with a retry request, together with a RAM correction, or with a plain bus error that forces the processor into exception handling. The policy is captured when a cycle opens, so changing the select during a cycle has no effect on that cycle. Every termination output stays asserted until the processor drops its cycle strobe, and it is released on the next clock.

Top module: `ecc_bus_term`

## Requirements
- R1: The policy select is decoded as bit 1 = early acknowledge and bit 0 = retry on error (00 late/exception, 01 late/retry, 10 early/exception, 11 early/retry). It is captured on the clock where a cycle opens, and changes to it during the cycle are ignored.
- R2: In the late policies `mem_ack` stays low until a check result is taken, and a good result raises `mem_ack` on the clock that samples it.
- R3: Late/retry with bad data raises `bus_err` and `bus_halt` on the same clock, with `mem_ack` low.
- R4: Late/exception with bad data raises `bus_err` alone, with `mem_ack` and `bus_halt` low.
- R5: In the early policies `mem_ack` rises on the clock that samples the opening of the cycle strobe. A good check result leaves only `mem_ack` asserted.
- R6: Early/exception with bad data raises `bus_err` on the clock after the acknowledge, while `mem_ack` stays high and `bus_halt` stays low.
- R7: Early/retry with bad data raises `bus_err` and `bus_halt` together on the clock after the acknowledge, while `mem_ack` stays high.
- R8: `fix_ram` pulses for exactly one clock, together with `bus_err` and `bus_halt`, only when an error is signalled under a retry policy.
- R9: All termination outputs are low on the clock after the cycle strobe is sampled low, including when a cycle is abandoned before its check result arrives.
- R10: `bus_halt` is never asserted without `bus_err`.
- R11: A check result presented while no cycle is waiting for one (idle, or after termination) changes no output.
- R12: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_strobe | input | 1 | Processor cycle strobe; high for the length of a read cycle |
| mode | input | 2 | Termination policy select (bit 1 early, bit 0 retry) |
| chk_valid | input | 1 | Check result is present this clock |
| chk_err | input | 1 | Check result flags the data as bad (meaningful with chk_valid) |
| mem_ack | output | 1 | Data acknowledge |
| bus_err | output | 1 | Bus error; takes priority over mem_ack at the processor |
| bus_halt | output | 1 | Halt request; together with bus_err it asks for a retry |
| fix_ram | output | 1 | One-clock request to write the corrected word back to RAM |

## Verification
The assertions assume that the cycle strobe stays low for at least one clock between cycles. They also assume that the policy select is stable on the clock where the strobe is first seen high, because the early-acknowledge checks read it there. The directed tasks open each cycle from an idle bus with a fixed select. They change the select and present stray check results only once the cycle is under way or has ended, and they always drop the strobe and wait for release before starting the next cycle.

// File: rtl/ecc_bus_term_pkg.sv
package ecc_bus_term_pkg;

    localparam int MODE_W     = 2;
    localparam int EARLY_BIT  = 1;
    localparam int RETRY_BIT  = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HOLD = 2'd2
    } term_state_e;

    typedef struct packed {
        term_state_e state;
        logic        early;
        logic        retry;
        logic        ack;
        logic        err;
        logic        halt;
        logic        fix;
    } term_regs_t;

    localparam term_regs_t TERM_RESET = '{
        state: ST_IDLE,
        early: 1'b0,
        retry: 1'b0,
        ack:   1'b0,
        err:   1'b0,
        halt:  1'b0,
        fix:   1'b0
    };

endpackage

// File: rtl/term_policy_decode.sv
module term_policy_decode #(
    parameter int MODE_W    = 2,
    parameter int EARLY_BIT = 1,
    parameter int RETRY_BIT = 0
) (
    input  logic [MODE_W-1:0] mode,
    output logic              early,
    output logic              retry
);

    always_comb begin
        early = mode[EARLY_BIT];
        retry = mode[RETRY_BIT];
    end

endmodule

// File: rtl/term_verdict.sv
module term_verdict (
    input  logic bad_data,
    input  logic retry,
    input  logic ack_now,
    output logic ack_next,
    output logic err_next,
    output logic halt_next,
    output logic fix_next
);

    always_comb begin
        if (bad_data) begin
            // early policies keep their acknowledge; the bus error wins at the processor
            ack_next  = ack_now;
            err_next  = 1'b1;
            halt_next = retry;
            fix_next  = retry;
        end else begin
            ack_next  = 1'b1;
            err_next  = 1'b0;
            halt_next = 1'b0;
            fix_next  = 1'b0;
        end
    end

endmodule

// File: rtl/ecc_bus_term.sv
module ecc_bus_term
    import ecc_bus_term_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_strobe,
    input  logic [MODE_W-1:0] mode,
    input  logic              chk_valid,
    input  logic              chk_err,
    output logic              mem_ack,
    output logic              bus_err,
    output logic              bus_halt,
    output logic              fix_ram
);

    term_regs_t regs_d;
    term_regs_t regs_q;

    logic dec_early;
    logic dec_retry;
    logic v_ack;
    logic v_err;
    logic v_halt;
    logic v_fix;

    term_policy_decode #(
        .MODE_W    (MODE_W),
        .EARLY_BIT (EARLY_BIT),
        .RETRY_BIT (RETRY_BIT)
    ) i_decode (
        .mode  (mode),
        .early (dec_early),
        .retry (dec_retry)
    );

    term_verdict i_verdict (
        .bad_data  (chk_err),
        .retry     (regs_q.retry),
        .ack_now   (regs_q.ack),
        .ack_next  (v_ack),
        .err_next  (v_err),
        .halt_next (v_halt),
        .fix_next  (v_fix)
    );

    always_comb begin
        regs_d     = regs_q;
        regs_d.fix = 1'b0;
        if (!cyc_strobe) begin
            // cycle over or abandoned: release the bus on this clock
            regs_d = TERM_RESET;
        end else begin
            unique case (regs_q.state)
                ST_IDLE: begin
                    regs_d.state = ST_WAIT;
                    regs_d.early = dec_early;
                    regs_d.retry = dec_retry;
                    regs_d.ack   = dec_early;
                end
                ST_WAIT: begin
                    if (chk_valid) begin
                        regs_d.state = ST_HOLD;
                        regs_d.ack   = v_ack;
                        regs_d.err   = v_err;
                        regs_d.halt  = v_halt;
                        regs_d.fix   = v_fix;
                    end
                end
                ST_HOLD: begin
                    regs_d.state = ST_HOLD;
                end
                default: begin
                    regs_d = TERM_RESET;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= TERM_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mem_ack  = regs_q.ack;
    assign bus_err  = regs_q.err;
    assign bus_halt = regs_q.halt;
    assign fix_ram  = regs_q.fix;

endmodule

// File: rtl/ecc_bus_term_checker.sv
module ecc_bus_term_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_strobe,
    input logic [1:0] mode,
    input logic       mem_ack,
    input logic       bus_err,
    input logic       bus_halt,
    input logic       fix_ram
);

    p_halt_needs_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_halt |-> bus_err);

    p_fix_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fix_ram |=> !fix_ram);

    p_fix_in_retry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fix_ram |-> (bus_err && bus_halt));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_strobe |=> (!mem_ack && !bus_err && !bus_halt && !fix_ram));

    p_err_drops_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_err) |-> !$past(cyc_strobe));

    p_early_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cyc_strobe) && mode[1]) |=> mem_ack);

    p_late_no_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cyc_strobe) && !mode[1]) |=> !mem_ack);

endmodule

bind ecc_bus_term ecc_bus_term_checker i_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_strobe (cyc_strobe),
    .mode       (mode),
    .mem_ack    (mem_ack),
    .bus_err    (bus_err),
    .bus_halt   (bus_halt),
    .fix_ram    (fix_ram)
);

// File: tb/test_ecc_bus_term.sv
module test_ecc_bus_term;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_strobe = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       chk_valid = 1'b0;
    logic       chk_err = 1'b0;
    logic       mem_ack;
    logic       bus_err;
    logic       bus_halt;
    logic       fix_ram;

    int checks = 0;
    int fails  = 0;
    int ticks  = 0;

    always #10 clk = ~clk;

    ecc_bus_term i_ecc_bus_term (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_strobe (cyc_strobe),
        .mode       (mode),
        .chk_valid  (chk_valid),
        .chk_err    (chk_err),
        .mem_ack    (mem_ack),
        .bus_err    (bus_err),
        .bus_halt   (bus_halt),
        .fix_ram    (fix_ram)
    );

    task automatic expect4(input string req, input logic a, input logic e,
                           input logic h, input logic f);
        logic [3:0] got;
        logic [3:0] exp;
        got = {mem_ack, bus_err, bus_halt, fix_ram};
        exp = {a, e, h, f};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: {ack,err,halt,fix} actual %b expected %b at %0t",
                     req, got, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // one complete read cycle; inputs change and outputs are sampled on falling edges
    task automatic run_cycle(input logic [1:0] m, input logic bad, input int gap);
        logic early;
        logic retry;
        logic exp_ack;
        early = m[1];
        retry = m[0];
        cyc_strobe = 1'b1;
        mode = m;
        @(negedge clk);
        // R5 early ack / R2 late no ack
        expect4(early ? "R5" : "R2", early, 1'b0, 1'b0, 1'b0);
        mode = ~m; // R1: change ignored mid-cycle
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            expect4(early ? "R5" : "R2", early, 1'b0, 1'b0, 1'b0);
        end
        chk_valid = 1'b1;
        chk_err = bad;
        @(negedge clk);
        chk_valid = 1'b0;
        chk_err = 1'b0;
        exp_ack = bad ? early : 1'b1;
        if (!bad)
            expect4(early ? "R5" : "R2", 1'b1, 1'b0, 1'b0, 1'b0);
        else if (!early && retry)
            expect4("R3", 1'b0, 1'b1, 1'b1, 1'b1);
        else if (!early)
            expect4("R4", 1'b0, 1'b1, 1'b0, 1'b0);
        else if (!retry)
            expect4("R6", 1'b1, 1'b1, 1'b0, 1'b0);
        else
            expect4("R7", 1'b1, 1'b1, 1'b1, 1'b1);
        // R11: stray result after termination
        chk_valid = 1'b1;
        chk_err = ~bad;
        @(negedge clk);
        expect4("R8", exp_ack, bad, bad & retry, 1'b0);
        chk_valid = 1'b0;
        @(negedge clk);
        expect4("R11", exp_ack, bad, bad & retry, 1'b0);
        cyc_strobe = 1'b0;
        mode = 2'b00;
        @(negedge clk);
        expect4("R9", 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
    endtask

    task automatic abort_and_stray();
        cyc_strobe = 1'b1;
        mode = 2'b01;
        @(negedge clk);
        expect4("R2", 1'b0, 1'b0, 1'b0, 1'b0);
        cyc_strobe = 1'b0;
        chk_valid = 1'b1;
        chk_err = 1'b1;
        @(negedge clk);
        expect4("R9", 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        expect4("R11", 1'b0, 1'b0, 1'b0, 1'b0);
        chk_valid = 1'b0;
        chk_err = 1'b0;
        @(negedge clk);
    endtask

    task automatic early_abort();
        cyc_strobe = 1'b1;
        mode = 2'b11;
        @(negedge clk);
        expect4("R5", 1'b1, 1'b0, 1'b0, 1'b0);
        cyc_strobe = 1'b0;
        @(negedge clk);
        expect4("R9", 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        ticks++;
        if (ticks > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", ticks);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect4("R12", 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        expect4("R12", 1'b0, 1'b0, 1'b0, 1'b0);
        for (int m = 0; m < 4; m++) begin
            run_cycle(m[1:0], 1'b0, 0);
            run_cycle(m[1:0], 1'b1, 0);
        end
        run_cycle(2'b00, 1'b0, 3);
        run_cycle(2'b01, 1'b1, 2);
        run_cycle(2'b11, 1'b1, 2);
        run_cycle(2'b10, 1'b1, 1);
        abort_and_stray();
        early_abort();
        run_cycle(2'b01, 1'b1, 0);
        summary();
    end

endmodule